// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This controller turns single-beat requests from a synchronous valid/ready port into correctly timed strobe sequences for an external asynchronous static RAM. Every strobe edge sits on a clock edge. The number of cycles each phase lasts is derived at elaboration from nanosecond minimums and the clock period, rounding up. The external data bus is presented as separate drive value, drive enable and sampled input, so the tristate pad stays outside the block.

A write keeps output enable high and drives data from the cycle in which write enable falls. The write is closed by write enable rising while chip enable is still low, and data is held one more cycle after that. A read holds chip enable and output enable low for the access time. The data bus is sampled at the edge that ends the read, and the value is returned with a one-cycle valid pulse. Between accesses the controller spends at least one idle cycle with every strobe high. This gives the memory's outputs time to float before the controller drives the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, mem_ce_no, mem_we_no and mem_oe_no are high, mem_dq_oe_o is low, req_ready_o is high and rsp_valid_o is low.
- R2: req_ready_o is high only while no access is in progress, with all three strobes high. A request is taken on a clock edge where req_valid_i and req_ready_o are both high. Its address and write data are registered at that edge, so later changes on the request inputs do not affect the access.
- R3: A write (req_wr_i = 1) holds mem_we_no low for exactly WLO cycles, with mem_ce_no low and mem_oe_no high throughout. WLO is the largest of ceil(pulse width / period), ceil(data setup / period), ceil(address-to-end / period) and ceil(chip-enable-to-end / period).
- R4: Every write is ended by mem_we_no rising while mem_ce_no is still low. mem_dq_oe_o is high from the cycle in which mem_we_no falls through the cycle after it rises, and mem_dq_o stays constant while mem_we_no is low.
- R5: Each write keeps mem_ce_no low for WLO + WHI cycles, where WHI = max(1, ceil(write cycle / period) - WLO).
- R6: A read (req_wr_i = 0) holds mem_ce_no and mem_oe_no low for exactly RD = max(ceil(access time / period), ceil(read cycle / period)) cycles, with mem_we_no high and mem_dq_oe_o low.
- R7: Read data is the mem_dq_i value at the clock edge that ends the read. It appears on rsp_rdata_o with rsp_valid_o high for exactly one cycle, which is the (RD+1)-th cycle after the accepting edge.
- R8: mem_dq_oe_o is never high while mem_oe_no is low. Every rise of mem_dq_oe_o is preceded by a cycle with mem_oe_no high and the bus undriven.
- R9: mem_addr_o does not change while mem_ce_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| rsp_rdata_o | output | DW | Read data |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| mem_addr_o | output | AW | Memory address bus |
| mem_dq_o | output | DW | Value driven onto the memory data bus |
| mem_dq_oe_o | output | 1 | Drive enable for the memory data bus |
| mem_dq_i | input | DW | Value sampled from the memory data bus |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |

## Verification
A cycle-level memory stand-in returns the inverse of the stored word until the address and output enable have been stable for RD-1 cycles. A read that samples too early therefore returns a value that is clearly wrong. The memory is swept over every address with initial contents, then with a written pattern, and then with interleaved write-after-read, read-after-write and repeated-overwrite sequences. The initial-contents pass separates correct read timing from early sampling. The written pattern separates a write committed at the terminating edge from a lost or misaddressed one. The mixed orders exercise the bus turnaround and the strobe run lengths in both directions. The request inputs are scrambled right after each acceptance, which shows whether the address and data were latched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WLO  = 2'd2,
    ST_WHI  = 2'd3
  } st_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WLO = 1,
  parameter int unsigned WHI = 1,
  parameter int unsigned RD  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_wr_i,
  output logic ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);
  localparam int unsigned MAXC = umax(WLO, umax(WHI, RD));
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ce_q, we_q, oe_q, dqoe_q;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = ready_o & req_valid_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    capture_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        st_d  = req_wr_i ? ST_WLO : ST_RD;
        cnt_d = req_wr_i ? CW'(WLO - 1) : CW'(RD - 1);
      end
      ST_RD: if (cnt_q == '0) begin
        st_d      = ST_IDLE;
        capture_o = 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      ST_WLO: if (cnt_q == '0) begin
        st_d  = ST_WHI;
        cnt_d = CW'(WHI - 1);
      end else cnt_d = cnt_q - 1'b1;
      ST_WHI: if (cnt_q == '0) st_d = ST_IDLE;
              else cnt_d = cnt_q - 1'b1;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes are flops decoded from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      dqoe_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ce_q   <= (st_d == ST_IDLE);
      we_q   <= (st_d != ST_WLO);
      oe_q   <= (st_d != ST_RD);
      dqoe_q <= (st_d == ST_WLO) | (st_q == ST_WLO);
    end
  end

  assign ce_no   = ce_q;
  assign we_no   = we_q;
  assign oe_no   = oe_q;
  assign dq_oe_o = dqoe_q;

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= dq_i;
      rvalid_q <= capture_i;
    end
  end

  assign addr_o   = addr_q;
  assign dq_o     = wdata_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned PER_NS   = 10,
  parameter int unsigned T_PWE_NS = 10,
  parameter int unsigned T_SD_NS  = 7,
  parameter int unsigned T_AW_NS  = 10,
  parameter int unsigned T_SCE_NS = 10,
  parameter int unsigned T_WC_NS  = 12,
  parameter int unsigned T_AA_NS  = 12,
  parameter int unsigned T_RC_NS  = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_wr_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no
);
  localparam int unsigned WLO_C = umax(umax(ns2cyc(T_PWE_NS, PER_NS), ns2cyc(T_SD_NS, PER_NS)),
                                       umax(umax(ns2cyc(T_AW_NS, PER_NS), ns2cyc(T_SCE_NS, PER_NS)), 1));
  localparam int unsigned WC_C  = ns2cyc(T_WC_NS, PER_NS);
  localparam int unsigned WHI_C = (WC_C > WLO_C + 1) ? (WC_C - WLO_C) : 1;
  localparam int unsigned RD_C  = umax(umax(ns2cyc(T_AA_NS, PER_NS), ns2cyc(T_RC_NS, PER_NS)), 1);

  logic accept, capture;

  sram_ctrl_fsm #(.WLO(WLO_C), .WHI(WHI_C), .RD(RD_C)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_wr_i   (req_wr_i),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce_no      (mem_ce_no),
    .we_no      (mem_we_no),
    .oe_no      (mem_oe_no),
    .dq_oe_o    (mem_dq_oe_o)
  );

  sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .capture_i(capture),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .dq_i     (mem_dq_i),
    .addr_o   (mem_addr_o),
    .dq_o     (mem_dq_o),
    .rdata_o  (rsp_rdata_o),
    .rvalid_o (rsp_valid_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 16,
  parameter int unsigned WLO = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_ce_no,
  input logic          mem_we_no,
  input logic          mem_oe_no,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_dq_o
);
  logic [7:0] we_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         we_cnt <= '0;
    else if (!mem_we_no) we_cnt <= we_cnt + 8'd1;
    else                 we_cnt <= '0;
  end

  // R2
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_we_no && mem_oe_no));
  // R3
  we_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no));
  // R3
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_cnt == 8'(WLO)));
  // R4
  we_ends_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (!mem_ce_no && mem_dq_oe_o));
  // R4
  drive_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> mem_dq_oe_o);
  // R4
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> $stable(mem_dq_o));
  // R6
  read_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_ce_no && mem_we_no));
  // R7
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R8
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
  // R8
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no));
  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW), .WLO(WLO_C)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_ce_no  (mem_ce_no),
  .mem_we_no  (mem_we_no),
  .mem_oe_no  (mem_oe_no),
  .mem_dq_oe_o(mem_dq_oe_o),
  .mem_addr_o (mem_addr_o),
  .mem_dq_o   (mem_dq_o)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int PER = 10;

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // expected cycle counts from the nanosecond minimums
  localparam int WLO_E = mx(mx(cdiv(10, PER), cdiv(7, PER)), mx(cdiv(10, PER), cdiv(10, PER)));
  localparam int WHI_E = mx(1, cdiv(12, PER) - WLO_E);
  localparam int RD_E  = mx(cdiv(12, PER), cdiv(12, PER));

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni, req_valid, req_ready, req_wr, rsp_valid;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_o, mem_dq_i;
  logic          mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;

  sram_ctrl #(
    .AW(AW), .DW(DW), .PER_NS(PER), .T_PWE_NS(10), .T_SD_NS(7), .T_AW_NS(10),
    .T_SCE_NS(10), .T_WC_NS(12), .T_AA_NS(12), .T_RC_NS(12)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rsp_rdata), .rsp_valid_o(rsp_valid),
    .mem_addr_o(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n), .mem_oe_no(mem_oe_n)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory stand-in and strobe monitor, both on the falling edge
  logic [DW-1:0] mdl [NW];
  logic [DW-1:0] sh  [NW];
  logic          p_ce, p_we, p_oe, p_dqoe;
  logic [AW-1:0] p_addr, acc_addr;
  logic [DW-1:0] p_dq;
  int            ce_run, we_run, rd_age;
  bit            acc_wr, addr_moved;

  initial begin
    for (int i = 0; i < NW; i++) begin
      mdl[i] = DW'(8'hA5 ^ i);
      sh[i]  = DW'(8'hA5 ^ i);
    end
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      p_ce = 1'b1; p_we = 1'b1; p_oe = 1'b1; p_dqoe = 1'b0;
      p_addr = '0; p_dq = '0; ce_run = 0; we_run = 0; rd_age = 0;
      acc_wr = 1'b0; addr_moved = 1'b0; mem_dq_i = '0;
    end else begin
      // write commits at the edge that closes the overlap
      if (!p_ce && !p_we && (mem_we_n || mem_ce_n)) begin
        mdl[p_addr] = p_dq;
        chk(!mem_ce_n && mem_dq_oe, "R4 end-by-we/hold", {mem_ce_n, mem_dq_oe}, 1);
      end
      if (!mem_ce_n) begin
        if (p_ce) begin
          ce_run = 1; acc_addr = mem_addr; acc_wr = 1'b0; addr_moved = 1'b0;
        end else begin
          ce_run++;
          if (mem_addr != acc_addr) addr_moved = 1'b1;
        end
        if (!mem_we_n) acc_wr = 1'b1;
      end else if (!p_ce) begin
        chk(!addr_moved, "R9 addr hold", int'(addr_moved), 0);
        if (acc_wr) chk(ce_run == WLO_E + WHI_E, "R5 write ce width", ce_run, WLO_E + WHI_E);
        else        chk(ce_run == RD_E, "R6 read ce width", ce_run, RD_E);
      end
      if (!mem_we_n) we_run = p_we ? 1 : we_run + 1;
      else if (!p_we) chk(we_run == WLO_E, "R3 we width", we_run, WLO_E);
      if (mem_dq_oe && !p_dqoe)
        chk(p_oe && mem_oe_n, "R8 turnaround", {p_oe, mem_oe_n}, 3);
      if (!mem_ce_n && !mem_oe_n) begin
        rd_age = (!p_ce && !p_oe && mem_addr == p_addr) ? rd_age + 1 : 0;
        mem_dq_i = (rd_age >= RD_E - 1) ? mdl[mem_addr] : ~mdl[mem_addr];
      end else begin
        rd_age = 0;
        mem_dq_i = '0;
      end
      p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe;
      p_addr = mem_addr; p_dq = mem_dq_o;
    end
  end

  // issue one request; returns after the accepting edge, at the next falling edge
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_wr = ~wr;
    chk(!req_ready, "R2 busy after accept", int'(req_ready), 0);
    chk(mem_addr == a, "R2 address latched", int'(mem_addr), int'(a));
  endtask

  task automatic do_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    issue(1'b1, a, d);
    sh[a] = d;
  endtask

  task automatic do_rd(logic [AW-1:0] a);
    int n;
    issue(1'b0, a, '0);
    n = 1;
    while (!rsp_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == RD_E + 1, "R7 read latency", n, RD_E + 1);
    chk(rsp_rdata == sh[a], "R7 read data", int'(rsp_rdata), int'(sh[a]));
    @(negedge clk);
    chk(!rsp_valid, "R7 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    rst_ni = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe, "R1 bus released in reset", int'(mem_dq_oe), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe, "R1 bus released", int'(mem_dq_oe), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);
    chk(!rsp_valid, "R1 no rvalid", int'(rsp_valid), 0);

    // initial contents, every address
    for (int a = 0; a < NW; a++) do_rd(AW'(a));
    // fill with a pattern, then read it all back
    for (int a = 0; a < NW; a++) do_wr(AW'(a), DW'((a * 37 + 11) & 8'hFF));
    for (int a = 0; a < NW; a++) do_rd(AW'(a));
    // alternating read/write orders, both turnaround directions
    for (int a = 0; a < NW; a++) begin
      do_rd(AW'(a));
      do_wr(AW'(NW - 1 - a), DW'((a * 91 + 3) & 8'hFF));
      do_rd(AW'(NW - 1 - a));
    end
    // repeated overwrite of one location
    do_wr(AW'(0), DW'(8'h00));
    do_wr(AW'(0), DW'(8'hFF));
    do_rd(AW'(0));
    do_wr(AW'(NW - 1), DW'(8'h5A));
    do_wr(AW'(NW - 1), DW'(8'hC3));
    do_rd(AW'(NW - 1));

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule